// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block keeps one interrupt-enable register and one interrupt-status register for each of several localities (five by default). All localities share a single level interrupt line. Event pulses come from logic outside the block, and each pulse carries a locality number and a mask of sources. The four sources are locality-changed, command-ready, data-available and status-valid. A source bit is latched into the status register of the tagged locality only when that locality's global-enable bit and the source's own enable bit are both set. A latched event also raises the shared line.

Software reaches the registers through a simple single-cycle write port and a combinational read port. Each access is addressed by a locality and a register select. Any locality may read. Only the locality that currently owns the interface may change its enable or status register. Writing ones to status bits clears them. The line drops when the writing locality's status register ends up all zero. The vector register holds a fixed value and never changes.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset, every locality's enable register reads 32'h0000_0008 (global enable clear, all source enables clear, polarity field bits 4:3 = 2'b01 meaning low level), every status register reads 0, and `irq_o` is 0.
- R2: A write to an enable register stores only bit 31 (global enable), bits 4:3 (polarity) and the source bits 0, 1, 2 and 7, so writing 32'hFFFF_FFFF reads back 32'h8000_009F.
- R3: A write to an enable or status register is ignored unless `own_vld` is 1 and `wr_loc` equals `own_loc`.
- R4: An event for locality L sets the selected status bits of L and sets `irq_o` at the next clock edge, provided L's bit 31 and the matching source enable bits are set.
- R5: An event whose locality has bit 31 clear, or whose source enable bit is clear, leaves that status bit and `irq_o` unchanged.
- R6: An event tagged with a locality number of `NUM_LOC` or more changes no register and does not touch `irq_o`.
- R7: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: `irq_o` falls after a status write that carries at least one source bit and takes the writer's nonzero status to zero, even if another locality still has status bits set. While any status bit of the writer remains set, `irq_o` stays high.
- R9: Select code 2'd2 (vector) always reads `VEC_VALUE`, and writes to it are ignored. Select codes are 0 = enable, 1 = status, 2 = vector, 3 = reserved (reads 0).
- R10: Event source mask bit 0 (data available) maps to status bit 0, bit 1 (status valid) to status bit 1, bit 2 (locality changed) to status bit 2, and bit 3 (command ready) to status bit 7.
- R11: When an event and a status-clear write hit the same locality in one cycle, the event's bits survive and `irq_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_vld | input | 1 | A locality currently owns the interface |
| own_loc | input | LOC_W | Owning locality number |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | LOC_W | Locality addressed by the write |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_loc | input | LOC_W | Locality addressed by the read |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| evt_vld | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_src | input | 4 | Source mask of the event |
| irq_o | output | 1 | Shared level interrupt line |

## Verification
The bound checker checks on every cycle that enable and status registers never hold bits outside their legal masks, and that an enabled event always raises the line. It also checks that the line never rises without an event and that a write from a non-owner leaves status untouched. It checks as well that a clearing write that empties the writer's status lowers the line. Other behaviours depend on register contents built up over several writes, so only the bench's directed scenarios can show them. These include the exact read-back values and the source-to-bit mapping. They also include the line dropping while another locality still has bits pending, the precedence of an event over a same-cycle clear, and ignored writes to the vector register.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
   localparam int DW       = 32;
   localparam int NUM_SRC  = 4;
   localparam int GEN_BIT  = 31;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_VECTOR = 2'd2,
      SEL_RSVD   = 2'd3
   } reg_sel_e;

   // status / enable bit position of each event source
   function automatic int src_pos(input int idx);
      case (idx)
         0:       return 0;   // data available
         1:       return 1;   // status valid
         2:       return 2;   // locality changed
         default: return 7;   // command ready
      endcase
   endfunction

   function automatic logic [DW-1:0] src_expand(input logic [NUM_SRC-1:0] m);
      logic [DW-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_SRC; i++) r[src_pos(i)] = m[i];
      return r;
   endfunction

   localparam logic [DW-1:0] SRC_MASK = src_expand('1);
   localparam logic [DW-1:0] POL_MASK = 32'h0000_0018;
   localparam logic [DW-1:0] GEN_MASK = 32'h8000_0000;
   localparam logic [DW-1:0] EN_KEEP  = SRC_MASK | POL_MASK | GEN_MASK;
   localparam logic [DW-1:0] EN_RESET = 32'h0000_0008;
endpackage

// File: rtl/loc_irq_evt_dec.sv
module loc_irq_evt_dec
   import loc_irq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3
) (
   input  logic                evt_vld,
   input  logic [LOC_W-1:0]    evt_loc,
   input  logic [NUM_SRC-1:0]  evt_src,
   output logic [DW-1:0]       set_req [NUM_LOC]
);
   logic [DW-1:0] src_bits;

   assign src_bits = src_expand(evt_src);

   for (genvar l = 0; l < NUM_LOC; l++) begin : g_dec
      assign set_req[l] = (evt_vld && evt_loc == LOC_W'(l)) ? src_bits : '0;
   end
endmodule

// File: rtl/loc_irq_bank.sv
module loc_irq_bank
   import loc_irq_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en_wr,
   input  logic           st_wr,
   input  logic [DW-1:0]  wr_data,
   input  logic [DW-1:0]  set_req,
   output logic [DW-1:0]  en_q,
   output logic [DW-1:0]  st_q,
   output logic           set_any,
   output logic           lower_req
);
   logic [DW-1:0] set_hit;
   logic [DW-1:0] clr_bits;
   logic [DW-1:0] st_d;

   always_comb begin
      set_hit  = en_q[GEN_BIT] ? (set_req & en_q & SRC_MASK) : '0;
      clr_bits = st_wr ? (wr_data & SRC_MASK) : '0;
      st_d     = (st_q & ~clr_bits) | set_hit;
   end

   assign set_any   = |set_hit;
   assign lower_req = st_wr && (|clr_bits) && (|st_q) && (st_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= EN_RESET;
         st_q <= '0;
      end else begin
         if (en_wr) en_q <= wr_data & EN_KEEP;
         st_q <= st_d;
      end
   end
endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line #(
   parameter int NUM_LOC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LOC-1:0] set_any,
   input  logic [NUM_LOC-1:0] lower_req,
   output logic               irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            irq_q <= 1'b0;
      else if (|set_any)     irq_q <= 1'b1;
      else if (|lower_req)   irq_q <= 1'b0;
   end
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
   import loc_irq_pkg::*;
#(
   parameter int              NUM_LOC   = 5,
   parameter int              LOC_W     = 3,
   parameter logic [DW-1:0]   VEC_VALUE = 32'h0000_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                own_vld,
   input  logic [LOC_W-1:0]    own_loc,
   input  logic                wr_en,
   input  logic [LOC_W-1:0]    wr_loc,
   input  logic [1:0]          wr_sel,
   input  logic [DW-1:0]       wr_data,
   input  logic [LOC_W-1:0]    rd_loc,
   input  logic [1:0]          rd_sel,
   output logic [DW-1:0]       rd_data,
   input  logic                evt_vld,
   input  logic [LOC_W-1:0]    evt_loc,
   input  logic [NUM_SRC-1:0]  evt_src,
   output logic                irq_o
);
   localparam logic [LOC_W:0] LOC_LIM = (LOC_W+1)'(NUM_LOC);

   initial begin
      assert (NUM_LOC >= 1) else $error("NUM_LOC must be at least 1");
      assert (NUM_LOC <= (1 << LOC_W)) else $error("LOC_W too narrow for NUM_LOC");
   end

   logic [DW-1:0]       set_req [NUM_LOC];
   logic [DW-1:0]       en_arr  [NUM_LOC];
   logic [DW-1:0]       st_arr  [NUM_LOC];
   logic [NUM_LOC-1:0]  set_any;
   logic [NUM_LOC-1:0]  lower_req;
   logic [NUM_LOC*DW-1:0] en_flat;
   logic [NUM_LOC*DW-1:0] st_flat;
   logic                wr_ok;
   reg_sel_e            wsel;
   reg_sel_e            rsel;

   assign wsel  = reg_sel_e'(wr_sel);
   assign rsel  = reg_sel_e'(rd_sel);
   assign wr_ok = wr_en && own_vld && (wr_loc == own_loc) && ({1'b0, wr_loc} < LOC_LIM);

   loc_irq_evt_dec #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_dec (
      .evt_vld (evt_vld),
      .evt_loc (evt_loc),
      .evt_src (evt_src),
      .set_req (set_req)
   );

   for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
      logic hit;
      assign hit = wr_ok && (wr_loc == LOC_W'(l));
      loc_irq_bank u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_wr     (hit && wsel == SEL_ENABLE),
         .st_wr     (hit && wsel == SEL_STATUS),
         .wr_data   (wr_data),
         .set_req   (set_req[l]),
         .en_q      (en_arr[l]),
         .st_q      (st_arr[l]),
         .set_any   (set_any[l]),
         .lower_req (lower_req[l])
      );
      assign en_flat[l*DW +: DW] = en_arr[l];
      assign st_flat[l*DW +: DW] = st_arr[l];
   end

   loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_any   (set_any),
      .lower_req (lower_req),
      .irq_q     (irq_o)
   );

   always_comb begin
      rd_data = '0;
      case (rsel)
         SEL_VECTOR: rd_data = VEC_VALUE;
         SEL_ENABLE: for (int l = 0; l < NUM_LOC; l++)
                        if (rd_loc == LOC_W'(l)) rd_data = en_arr[l];
         SEL_STATUS: for (int l = 0; l < NUM_LOC; l++)
                        if (rd_loc == LOC_W'(l)) rd_data = st_arr[l];
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk
   import loc_irq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   own_vld,
   input logic [LOC_W-1:0]       own_loc,
   input logic                   wr_en,
   input logic [LOC_W-1:0]       wr_loc,
   input logic [1:0]             wr_sel,
   input logic [DW-1:0]          wr_data,
   input logic                   evt_vld,
   input logic [LOC_W-1:0]       evt_loc,
   input logic [NUM_SRC-1:0]     evt_src,
   input logic                   irq_o,
   input logic [NUM_LOC*DW-1:0]  en_flat,
   input logic [NUM_LOC*DW-1:0]  st_flat
);
   logic [DW-1:0] en_c [NUM_LOC];
   logic [DW-1:0] st_c [NUM_LOC];
   logic          evt_hit;
   logic          empty_wr;

   for (genvar l = 0; l < NUM_LOC; l++) begin : g_unpack
      assign en_c[l] = en_flat[l*DW +: DW];
      assign st_c[l] = st_flat[l*DW +: DW];
   end

   always_comb begin
      evt_hit  = 1'b0;
      empty_wr = 1'b0;
      for (int l = 0; l < NUM_LOC; l++) begin
         if (evt_vld && evt_loc == LOC_W'(l) && en_c[l][GEN_BIT] &&
             |(src_expand(evt_src) & en_c[l])) evt_hit = 1'b1;
         if (wr_en && own_vld && wr_loc == own_loc && wr_loc == LOC_W'(l) &&
             wr_sel == 2'd1 && st_c[l] != '0 &&
             ((st_c[l] & ~wr_data) == '0)) empty_wr = 1'b1;
      end
   end

   for (genvar l = 0; l < NUM_LOC; l++) begin : g_reg
      // R2
      enable_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_c[l] & ~EN_KEEP) == '0);
      // R7
      status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (st_c[l] & ~SRC_MASK) == '0);
      // R3
      foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_loc == LOC_W'(l) && !(own_vld && own_loc == LOC_W'(l)) &&
          !(evt_vld && evt_loc == LOC_W'(l)))
         |=> $stable(st_c[l]) && $stable(en_c[l]));
   end

   // R4
   event_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_hit |=> irq_o);

   // R5
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(evt_vld));

   // R8
   line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_wr && !evt_vld) |=> !irq_o);
endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .own_vld (own_vld),
   .own_loc (own_loc),
   .wr_en   (wr_en),
   .wr_loc  (wr_loc),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .evt_vld (evt_vld),
   .evt_loc (evt_loc),
   .evt_src (evt_src),
   .irq_o   (irq_o),
   .en_flat (en_flat),
   .st_flat (st_flat)
);

// File: tb/loc_irq_ctrl_test.sv
module loc_irq_ctrl_test;
   localparam int CLK_P = 10;
   localparam int LW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          own_vld = 1'b0;
   logic [LW-1:0] own_loc = '0;
   logic          wr_en = 1'b0;
   logic [LW-1:0] wr_loc = '0;
   logic [1:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic [LW-1:0] rd_loc = '0;
   logic [1:0]    rd_sel = '0;
   logic [31:0]   rd_data;
   logic          evt_vld = 1'b0;
   logic [LW-1:0] evt_loc = '0;
   logic [3:0]    evt_src = '0;
   logic          irq_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   loc_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .own_vld(own_vld), .own_loc(own_loc),
      .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data),
      .evt_vld(evt_vld), .evt_loc(evt_loc), .evt_src(evt_src), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input int loc, input int sel, output logic [31:0] d);
      rd_loc = LW'(loc);
      rd_sel = 2'(sel);
      #1;
      d = rd_data;
   endtask

   task automatic chk_reg(input string req, input int loc, input int sel, input logic [31:0] exp);
      logic [31:0] d;
      rd(loc, sel, d);
      check(req, d, exp);
   endtask

   // drive one cycle at negedge; registers update at the following posedge
   task automatic cycle(input bit w, input int wl, input int ws, input logic [31:0] wd,
                        input bit e, input int el, input logic [3:0] es);
      @(negedge clk);
      wr_en = w; wr_loc = LW'(wl); wr_sel = 2'(ws); wr_data = wd;
      evt_vld = e; evt_loc = LW'(el); evt_src = es;
      @(negedge clk);
      wr_en = 1'b0; evt_vld = 1'b0;
   endtask

   task automatic wr(input int l, input int s, input logic [31:0] d);
      cycle(1'b1, l, s, d, 1'b0, 0, 4'h0);
   endtask

   task automatic ev(input int l, input logic [3:0] s);
      cycle(1'b0, 0, 0, 32'h0, 1'b1, l, s);
   endtask

   task automatic own(input bit v, input int l);
      @(negedge clk);
      own_vld = v; own_loc = LW'(l);
   endtask

   task automatic t_reset;
      for (int l = 0; l < 5; l++) begin
         chk_reg("R1 enable", l, 0, 32'h0000_0008);
         chk_reg("R1 status", l, 1, 32'h0);
      end
      check("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_enable_mask;
      own(1'b1, 2);
      wr(1, 0, 32'hFFFF_FFFF);
      chk_reg("R3 foreign enable write", 1, 0, 32'h0000_0008);
      wr(2, 0, 32'hFFFF_FFFF);
      chk_reg("R2 enable mask", 2, 0, 32'h8000_009F);
   endtask

   task automatic t_mapping;
      ev(2, 4'b0001);
      chk_reg("R10 data avail bit0", 2, 1, 32'h01);
      check("R4 irq raised", {31'b0, irq_o}, 32'h1);
      ev(2, 4'b0010);
      chk_reg("R10 sts valid bit1", 2, 1, 32'h03);
      ev(2, 4'b0100);
      chk_reg("R10 loc changed bit2", 2, 1, 32'h07);
      ev(2, 4'b1000);
      chk_reg("R10 cmd ready bit7", 2, 1, 32'h87);
   endtask

   task automatic t_clear;
      wr(2, 1, 32'h0000_0001);
      chk_reg("R7 partial clear", 2, 1, 32'h86);
      check("R8 line held while bits remain", {31'b0, irq_o}, 32'h1);
      wr(2, 1, 32'h0000_0086);
      chk_reg("R7 full clear", 2, 1, 32'h0);
      check("R8 line lowered", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_foreign_status;
      ev(2, 4'b0001);
      own(1'b1, 3);
      wr(2, 1, 32'h0000_0001);
      chk_reg("R3 foreign status write", 2, 1, 32'h01);
      check("R3 irq kept", {31'b0, irq_o}, 32'h1);
      own(1'b0, 2);
      wr(2, 1, 32'h0000_0001);
      chk_reg("R3 no owner status write", 2, 1, 32'h01);
      wr(2, 0, 32'h0);
      chk_reg("R3 no owner enable write", 2, 0, 32'h8000_009F);
      own(1'b1, 2);
      wr(2, 1, 32'h0000_0001);
      chk_reg("R7 clear after regain", 2, 1, 32'h0);
   endtask

   task automatic t_gated;
      wr(2, 0, 32'h0000_009F);
      ev(2, 4'b1111);
      chk_reg("R5 global enable off", 2, 1, 32'h0);
      check("R5 irq stays low", {31'b0, irq_o}, 32'h0);
      wr(2, 0, 32'h8000_0001);
      ev(2, 4'b1110);
      chk_reg("R5 source disabled", 2, 1, 32'h0);
      check("R5 irq stays low 2", {31'b0, irq_o}, 32'h0);
      ev(2, 4'b0001);
      chk_reg("R4 single source", 2, 1, 32'h1);
      wr(2, 1, 32'h1);
      wr(2, 0, 32'h8000_009F);
   endtask

   task automatic t_bad_loc;
      for (int bl = 5; bl < 8; bl++) begin
         ev(bl, 4'b1111);
         check("R6 irq untouched", {31'b0, irq_o}, 32'h0);
      end
      for (int l = 0; l < 5; l++) chk_reg("R6 status untouched", l, 1, 32'h0);
   endtask

   task automatic t_shared_drop;
      ev(2, 4'b0001);
      own(1'b1, 4);
      wr(4, 0, 32'h8000_0001);
      ev(4, 4'b0001);
      check("R8 irq high both pending", {31'b0, irq_o}, 32'h1);
      wr(4, 1, 32'h1);
      check("R8 drop despite other locality", {31'b0, irq_o}, 32'h0);
      chk_reg("R8 other locality kept", 2, 1, 32'h1);
      own(1'b1, 2);
      wr(2, 1, 32'h1);
   endtask

   task automatic t_collide;
      ev(2, 4'b0001);
      cycle(1'b1, 2, 1, 32'h1, 1'b1, 2, 4'b0010);
      chk_reg("R11 set beats clear", 2, 1, 32'h2);
      check("R11 irq high", {31'b0, irq_o}, 32'h1);
      wr(2, 1, 32'h2);
   endtask

   task automatic t_vector;
      chk_reg("R9 vector value", 2, 2, 32'h0);
      wr(2, 2, 32'hFFFF_FFFF);
      chk_reg("R9 vector after write", 2, 2, 32'h0);
      chk_reg("R9 reserved reads zero", 2, 3, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_mask();
      t_mapping();
      t_clear();
      t_foreign_status();
      t_gated();
      t_bad_loc();
      t_shared_drop();
      t_collide();
      t_vector();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule